// File: doc/BRIEF.md
# UART Host Register File with Divisor Latch

This block is the processor-facing side of a UART. A host reaches it through a 3-bit register address, an 8-bit write bus, an 8-bit read bus and single-cycle read and write strobes. It holds the line-control byte, the interrupt-enable byte and a 16-bit baud divisor. It turns writes to the FIFO-control address into a stored FIFO enable and one-cycle FIFO clear pulses. It reports line status, with live ready and empty levels and sticky receive error flags. It also derives a one-cycle enable at sixteen times the bit rate by dividing the system clock by the programmed divisor.

Bit 7 of the line-control byte is the divisor-access switch. While it is 1, addresses 0 and 1 reach the divisor bytes. While it is 0, the same addresses reach the data path (transmit push, receive pop) and the interrupt-enable byte. Reads are combinational: the read bus shows the addressed register in the same cycle as the strobe. Register updates take effect at the clock edge that ends the strobe cycle.

Top module: `uart_host_regs`

## Requirements
- R1: While reset is low at a clock edge, line control, interrupt enable, divisor and FIFO enable become 0, the sticky error flags clear, and the FIFO clear pulses and the rate enable are 0 afterwards.
- R2: Address 3 is the line-control byte. A write stores all 8 bits, the byte is driven on `line_ctrl` from the next cycle, and a read of address 3 returns it.
- R3: While line-control bit 7 is 1, address 0 reads and writes the divisor low byte and address 1 the divisor high byte. Such accesses neither push, pop nor change the interrupt-enable byte.
- R4: While line-control bit 7 is 0, a write to address 0 raises `tx_push` in that cycle with `tx_byte` equal to the write data. A read of address 0 raises `rx_pop` and returns `rx_byte`. Address 1 reads and writes the interrupt-enable byte.
- R5: With divisor N > 0, `baud_x16_en` is high for one cycle in every N cycles. With divisor 0 it stays low.
- R6: A write to either divisor byte restarts the rate count. The first enable after such a write comes N cycles after the write edge, counting the write edge as the first.
- R7: A write to address 2 stores data bit 0 as `fifo_enable`. It raises `rx_fifo_clr` (data bit 1) and `tx_fifo_clr` (data bit 2) for exactly the next cycle only. Address 2 reads as 0.
- R8: Address 5 reads line status: bit 0 = `rx_avail`, bit 1 = overrun, bit 2 = parity, bit 3 = framing, bit 4 = break, bit 5 = `thr_empty`, bits 6 and 7 = 0. Bits 1 to 4 are set by a one-cycle event pulse and stay set.
- R9: A read of address 5 clears status bits 1 to 4 at the end of the read cycle. An event arriving in that same cycle stays set.
- R10: Addresses 4, 6 and 7 read as 0, and writes to them change no register and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_rdata | output | 8 | Read data for the addressed register, combinational |
| rx_byte | input | 8 | Head byte of the receive queue |
| rx_avail | input | 1 | Receive queue holds data |
| thr_empty | input | 1 | Transmit holding space is empty |
| ev_overrun | input | 1 | Overrun event pulse |
| ev_parity | input | 1 | Parity error event pulse |
| ev_framing | input | 1 | Framing error event pulse |
| ev_break | input | 1 | Break detect event pulse |
| tx_push | output | 1 | Push `tx_byte` into the transmit queue |
| tx_byte | output | 8 | Byte to transmit |
| rx_pop | output | 1 | Pop the receive queue head |
| line_ctrl | output | 8 | Line-control byte |
| int_enable | output | 8 | Interrupt-enable byte |
| fifo_enable | output | 1 | FIFO enable |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO clear |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO clear |
| baud_x16_en | output | 1 | One-cycle enable at 16x the bit rate |

## Verification
The read bus, `tx_push`, `tx_byte` and `rx_pop` are due in the strobe cycle itself. Stored registers, FIFO clear pulses and status clearing show in the cycle after the write or read edge. The rate enable follows a counter that restarts at each divisor write. A behavioural model in the bench updates its state at each rising edge from the inputs held in that cycle. One nanosecond after the falling edge, when the inputs for that cycle have just been applied, the model derives every output and compares it with the design. Each output is therefore compared in exactly the cycle its latency makes it due.

// File: rtl/uart_hostreg_pkg.sv
// Package: shared widths, register addresses and status layout for the UART
// host register file. Assumes an 8-bit bus and a two-byte divisor.
package uart_hostreg_pkg;
    localparam int ADDR_W    = 3;
    localparam int DW        = 8;
    localparam int DIV_BYTES = 2;
    localparam int DIV_W     = DW * DIV_BYTES;

    localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] A_IEN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_FCTL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_LCTL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_LSTAT = 3'd5;

    localparam int LCTL_DIVSEL = 7;
    localparam int FCTL_EN     = 0;
    localparam int FCTL_RXCLR  = 1;
    localparam int FCTL_TXCLR  = 2;

    // Sticky receive error flags; packed order sets status bits 4..1.
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } err_flags_t;
endpackage

// File: rtl/uart_baud_gen.sv
// Module: divides the system clock by a programmable divisor and emits a
// one-cycle enable every DIV cycles. Assumes divisor changes only together
// with a reload pulse. A divisor of 0 holds the counter and the enable low.
module uart_baud_gen
    import uart_hostreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             reload,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;

    // Enable when the count reaches the last step of the period.
    assign tick = (divisor != '0) && (cnt == divisor - ONE);

    // Advance the count, wrapping on the enable or restarting on reload.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (reload || (divisor == '0) || tick)
            cnt <= '0;
        else
            cnt <= cnt + ONE;
    end

    // R6: a divisor write restarts the period from zero.
    p_reload_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt == '0));

    // R5: after an enable the next cycle is quiet unless the divisor is 1.
    p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload && (divisor != ONE)) |=> !tick);

    // R5: a zero divisor keeps the counter parked.
    p_zero_div_parked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |=> (cnt == '0));
endmodule

// File: rtl/uart_cfg_regs.sv
// Module: configuration storage of the host register file: line control,
// interrupt enable, divisor bytes and FIFO control. Assumes one write strobe
// per access. Divisor bytes are selected by line-control bit 7.
module uart_cfg_regs
    import uart_hostreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     lcr,
    output logic [DW-1:0]     ier,
    output logic [DIV_W-1:0]  divisor,
    output logic              div_reload,
    output logic              fifo_en,
    output logic              rx_clr,
    output logic              tx_clr
);
    logic                 div_sel;
    logic                 lcr_wr;
    logic                 ier_wr;
    logic                 fcr_wr;
    logic [DIV_BYTES-1:0] byte_wr;

    assign div_sel = lcr[LCTL_DIVSEL];
    assign lcr_wr  = reg_wr && (reg_addr == A_LCTL);
    assign ier_wr  = reg_wr && (reg_addr == A_IEN) && !div_sel;
    assign fcr_wr  = reg_wr && (reg_addr == A_FCTL);

    // One storage byte per divisor byte, each at its own low address.
    for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div
        logic [DW-1:0] byte_q;

        assign byte_wr[b] = reg_wr && div_sel && (reg_addr == ADDR_W'(b));
        assign divisor[b*DW +: DW] = byte_q;

        // Hold one divisor byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= '0;
            else if (byte_wr[b])
                byte_q <= reg_wdata;
        end
    end

    assign div_reload = |byte_wr;

    // Hold the line-control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lcr <= '0;
        else if (lcr_wr)
            lcr <= reg_wdata;
    end

    // Hold the interrupt-enable byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ier <= '0;
        else if (ier_wr)
            ier <= reg_wdata;
    end

    // Store the FIFO enable and form the self-clearing clear pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en <= 1'b0;
            rx_clr  <= 1'b0;
            tx_clr  <= 1'b0;
        end else begin
            rx_clr <= fcr_wr && reg_wdata[FCTL_RXCLR];
            tx_clr <= fcr_wr && reg_wdata[FCTL_TXCLR];
            if (fcr_wr)
                fifo_en <= reg_wdata[FCTL_EN];
        end
    end

    // R2: line control changes only through its own address.
    p_lcr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lcr_wr |=> $stable(lcr));

    // R3: with divisor access selected the interrupt-enable byte is frozen.
    p_ier_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_sel |=> $stable(ier));

    // R3: the divisor only moves on a divisor byte write.
    p_div_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !div_reload |=> $stable(divisor));

    // R7: a clear pulse lasts one cycle when no new control write follows.
    p_rxclr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr && !fcr_wr) |=> !rx_clr);
    p_txclr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr && !fcr_wr) |=> !tx_clr);
endmodule

// File: rtl/uart_lsr_track.sv
// Module: assembles the line status byte from live ready/empty levels and
// sticky error flags. Assumes error events are single-cycle pulses. Set
// takes priority over a clear in the same cycle.
module uart_lsr_track
    import uart_hostreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  err_flags_t events,
    input  logic       clr,
    input  logic       rx_ready,
    input  logic       thr_empty,
    output logic [DW-1:0] status
);
    err_flags_t flags;

    // Accumulate error events; a status read wipes older ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (clr ? err_flags_t'('0) : flags) | events;
    end

    // Place the live levels around the sticky flags.
    assign status = {2'b00, thr_empty, flags, rx_ready};

    // R8: every event leaves its flag set in the next cycle.
    p_event_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (events != '0) |=> ((flags & $past(events)) == $past(events)));

    // R9: a status read with no new event leaves all flags clear.
    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (events == '0)) |=> (flags == '0));

    // R8: without a read, flags never drop.
    p_no_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/uart_host_regs.sv
// Module: top of the UART host register file. Decodes the host bus, returns
// read data combinationally and drives data-path strobes. Assumes reg_wr and
// reg_rd are never high together and each access lasts one cycle.
module uart_host_regs
    import uart_hostreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    input  logic        reg_wr,
    input  logic        reg_rd,
    output logic [7:0]  reg_rdata,
    input  logic [7:0]  rx_byte,
    input  logic        rx_avail,
    input  logic        thr_empty,
    input  logic        ev_overrun,
    input  logic        ev_parity,
    input  logic        ev_framing,
    input  logic        ev_break,
    output logic        tx_push,
    output logic [7:0]  tx_byte,
    output logic        rx_pop,
    output logic [7:0]  line_ctrl,
    output logic [7:0]  int_enable,
    output logic        fifo_enable,
    output logic        rx_fifo_clr,
    output logic        tx_fifo_clr,
    output logic        baud_x16_en
);
    logic [DIV_W-1:0] divisor;
    logic             div_reload;
    logic [DW-1:0]    status;
    logic             div_sel;
    logic             status_rd;
    err_flags_t       events;

    assign div_sel   = line_ctrl[LCTL_DIVSEL];
    assign status_rd = reg_rd && (reg_addr == A_LSTAT);
    assign events    = '{brk: ev_break, frm: ev_framing, par: ev_parity, ovr: ev_overrun};

    uart_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .lcr        (line_ctrl),
        .ier        (int_enable),
        .divisor    (divisor),
        .div_reload (div_reload),
        .fifo_en    (fifo_enable),
        .rx_clr     (rx_fifo_clr),
        .tx_clr     (tx_fifo_clr)
    );

    uart_lsr_track u_lsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .events    (events),
        .clr       (status_rd),
        .rx_ready  (rx_avail),
        .thr_empty (thr_empty),
        .status    (status)
    );

    uart_baud_gen u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .reload  (div_reload),
        .tick    (baud_x16_en)
    );

    // Data-path strobes on the shared low address.
    assign tx_push = reg_wr && (reg_addr == A_DATA) && !div_sel;
    assign rx_pop  = reg_rd && (reg_addr == A_DATA) && !div_sel;
    assign tx_byte = reg_wdata;

    // Select the read data for the addressed register.
    always_comb begin
        unique case (reg_addr)
            A_DATA:  reg_rdata = div_sel ? divisor[DW-1:0] : rx_byte;
            A_IEN:   reg_rdata = div_sel ? divisor[DIV_W-1:DW] : int_enable;
            A_LCTL:  reg_rdata = line_ctrl;
            A_LSTAT: reg_rdata = status;
            default: reg_rdata = '0;
        endcase
    end

    // R7: a receive-clear request is answered in the next cycle.
    p_rxclr_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == A_FCTL) && reg_wdata[FCTL_RXCLR]) |=> rx_fifo_clr);

    // R4: a transmit push never coincides with a read strobe.
    p_push_not_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> !reg_rd);
endmodule

// File: tb/sim_uart_host_regs.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the register file compared with the
// design on every clock, one nanosecond after the stimulus is applied.
module sim_uart_host_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] rx_byte = 8'hA7;
    logic       rx_avail = 1'b0;
    logic       thr_empty = 1'b1;
    logic [3:0] ev = '0;
    logic [7:0] reg_rdata, tx_byte, line_ctrl, int_enable;
    logic       tx_push, rx_pop, fifo_enable, rx_fifo_clr, tx_fifo_clr, baud_x16_en;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // Model state
    logic [7:0]  m_lcr = '0, m_ier = '0;
    logic [15:0] m_div = '0;
    logic        m_fen = 0, m_rxclr = 0, m_txclr = 0;
    logic [3:0]  m_flags = '0;
    int          m_cnt = 0;

    always #5 clk = ~clk;

    uart_host_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .rx_byte(rx_byte), .rx_avail(rx_avail), .thr_empty(thr_empty),
        .ev_overrun(ev[0]), .ev_parity(ev[1]), .ev_framing(ev[2]), .ev_break(ev[3]),
        .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop),
        .line_ctrl(line_ctrl), .int_enable(int_enable), .fifo_enable(fifo_enable),
        .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr), .baud_x16_en(baud_x16_en)
    );

    // Model update at each rising edge from the inputs held in the cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lcr = '0; m_ier = '0; m_div = '0; m_fen = 0;
            m_rxclr = 0; m_txclr = 0; m_flags = '0; m_cnt = 0;
        end else begin
            bit reload;
            bit tick;
            reload = 0;
            tick = (m_div != 0) && (m_cnt == int'(m_div) - 1);
            m_rxclr = 0; m_txclr = 0;
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: if (m_lcr[7]) begin m_div[7:0] = reg_wdata; reload = 1; end
                    3'd1: if (m_lcr[7]) begin m_div[15:8] = reg_wdata; reload = 1; end
                          else m_ier = reg_wdata;
                    3'd2: begin m_fen = reg_wdata[0]; m_rxclr = reg_wdata[1]; m_txclr = reg_wdata[2]; end
                    3'd3: m_lcr = reg_wdata;
                    default: ;
                endcase
            end
            if (reload || tick || m_div == 0) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            if (reg_rd && reg_addr == 3'd5) m_flags = '0;
            m_flags = m_flags | ev;
        end
    end

    task automatic chk(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus and compare every output against the model.
    task automatic cyc(input logic [2:0] a, input logic [7:0] d, input logic w,
                       input logic r, input logic [3:0] e);
        logic [7:0] e_rd;
        string rtag;
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = w; reg_rd = r; ev = e;
        #1;
        case (a)
            3'd0: begin e_rd = m_lcr[7] ? m_div[7:0] : rx_byte; rtag = m_lcr[7] ? "R3" : "R4"; end
            3'd1: begin e_rd = m_lcr[7] ? m_div[15:8] : m_ier; rtag = m_lcr[7] ? "R3" : "R4"; end
            3'd2: begin e_rd = 8'h00; rtag = "R7"; end
            3'd3: begin e_rd = m_lcr; rtag = "R2"; end
            3'd5: begin e_rd = {2'b00, thr_empty, m_flags, rx_avail}; rtag = "R8 R9"; end
            default: begin e_rd = 8'h00; rtag = "R10"; end
        endcase
        if (!rst_n) rtag = "R1";
        if (rst_n) chk(rtag, "reg_rdata", {8'h0, reg_rdata}, {8'h0, e_rd});
        chk(rst_n ? "R2" : "R1", "line_ctrl", {8'h0, line_ctrl}, {8'h0, m_lcr});
        chk(rst_n ? "R4" : "R1", "int_enable", {8'h0, int_enable}, {8'h0, m_ier});
        chk(rst_n ? "R7" : "R1", "fifo_enable", {15'h0, fifo_enable}, {15'h0, m_fen});
        chk(rst_n ? "R7" : "R1", "rx_fifo_clr", {15'h0, rx_fifo_clr}, {15'h0, m_rxclr});
        chk(rst_n ? "R7" : "R1", "tx_fifo_clr", {15'h0, tx_fifo_clr}, {15'h0, m_txclr});
        chk(rst_n ? "R5 R6" : "R1", "baud_x16_en", {15'h0, baud_x16_en},
            {15'h0, (m_div != 0) && (m_cnt == int'(m_div) - 1)});
        if (rst_n) begin
            chk("R4 R10", "tx_push", {15'h0, tx_push}, {15'h0, w && a == 3'd0 && !m_lcr[7]});
            chk("R4 R10", "rx_pop", {15'h0, rx_pop}, {15'h0, r && a == 3'd0 && !m_lcr[7]});
            if (tx_push) chk("R4", "tx_byte", {8'h0, tx_byte}, {8'h0, d});
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(3'd0, 8'h00, 1'b0, 1'b0, 4'h0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(a, d, 1'b1, 1'b0, 4'h0);
    endtask

    task automatic rd(input logic [2:0] a);
        cyc(a, 8'h00, 1'b0, 1'b1, 4'h0);
    endtask

    task automatic read_all();
        for (int a = 0; a < 8; a++) rd(3'(a));
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3);
        rst_n = 1'b1;
        read_all();
        // R2 R3: enter divisor access, program 4, then 1, then 0
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h04); wr(3'd1, 8'h00);
        idle(14);
        read_all();
        wr(3'd0, 8'h01); idle(5);
        wr(3'd0, 8'h00); idle(6);
        // R5: large divisor 0x100
        wr(3'd1, 8'h01); idle(520);
        // R6: restart mid-period with divisor 3
        wr(3'd0, 8'h03); idle(2);
        wr(3'd1, 8'h00); idle(10);
        wr(3'd0, 8'h05); idle(3); wr(3'd0, 8'h05); idle(8);
        // R3: shared addresses reach divisor, no push/pop/ier change
        rd(3'd0); rd(3'd1); wr(3'd1, 8'h02); rd(3'd1); wr(3'd1, 8'h00);
        // R4: data path with divisor access off
        wr(3'd3, 8'h1B);
        wr(3'd0, 8'h55); rd(3'd0);
        rx_byte = 8'h3C; rd(3'd0);
        wr(3'd1, 8'h0F); rd(3'd1); idle(4);
        // R7: FIFO control
        wr(3'd2, 8'h07); idle(2); rd(3'd2);
        wr(3'd2, 8'h02); wr(3'd2, 8'h04); wr(3'd2, 8'h00); idle(2);
        // R8: status levels and sticky flags
        rx_avail = 1'b1; thr_empty = 1'b0; rd(3'd5);
        cyc(3'd0, 8'h00, 1'b0, 1'b0, 4'b0001); idle(2); rd(3'd5); rd(3'd5);
        cyc(3'd0, 8'h00, 1'b0, 1'b0, 4'b1010); idle(1);
        // R9: read clears, simultaneous event survives
        cyc(3'd5, 8'h00, 1'b0, 1'b1, 4'b0100); rd(3'd5); rd(3'd5);
        cyc(3'd0, 8'h00, 1'b0, 1'b0, 4'b1111); rd(3'd5); rd(3'd5);
        rx_avail = 1'b0; thr_empty = 1'b1; rd(3'd5);
        // R10: unmapped addresses
        wr(3'd4, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        read_all();
        // R1: reset mid-run
        wr(3'd3, 8'h80); wr(3'd0, 8'h02);
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        read_all(); idle(4);
        done = 1;
        summary();
        $finish;
    end
endmodule